// File: doc/BRIEF.md
# Hamming ECC syndrome corrector

This block decides what to do with one 512-byte chunk after a page read. Two inputs describe the chunk. The first is the 3-byte code that was stored in the spare area. The second is the 32-bit word that the checksum engine produced for the same chunk. That word carries the freshly computed code, inverted, in its low three bytes. It also carries status flags in its upper bits.

The block rearranges each code into a 12-bit lower half and a 12-bit upper half. It XORs the matching halves to form an odd syndrome and an even syndrome, then sorts the chunk into one of four outcomes:

- clean, with no error;
- a single flipped data bit, reported with its byte and bit position;
- a single flipped bit inside the stored code itself, where the data needs no repair;
- uncorrectable.

A page of up to 2 KiB is handled as up to four chunks, one start strobe per chunk. For a data error the block also drives a one-hot byte mask. Software or a buffer engine XORs that mask into the addressed byte. A chunk whose engine word is not marked valid is skipped.

Top module: `ecc_syndrome_corrector`

## Requirements
- R1: While rst_ni is low and after its release, done_o is 0, status_o is 0, byte_off_o is 0, bit_off_o is 0, flip_mask_o is 0 and nflips_o is 0 until the first accepted start.
- R2: A start is accepted when start_i is 1 and bit 30 (valid) of engine_word_i is 1 at a rising clock edge. done_o is 1 for exactly the following cycle and carries that chunk's result.
- R3: The stored code takes byte 0 from stored_code_i[7:0], byte 1 from [15:8] and byte 2 from [23:16]. The computed code is the bitwise inverse of engine_word_i[23:0], with byte 0 in bits [7:0]. For both codes, the lower half is byte 0 with the low nibble of byte 1 above it. The upper half is byte 2 with the high nibble of byte 1 below it. The odd syndrome is the XOR of the lower halves and the even syndrome is the XOR of the upper halves.
- R4: When both syndromes are zero, status_o is 0 (clean).
- R5: When the odd syndrome equals the 12-bit complement of the even syndrome, status_o is 1 (data error). byte_off_o is odd syndrome bits [11:3] (0 to 511) and bit_off_o is odd syndrome bits [2:0].
- R6: When the OR of the two syndromes has exactly one bit set, status_o is 2 (error in the code bytes).
- R7: Every other syndrome pattern gives status_o 3 (uncorrectable).
- R8: When bit 28 (failed) of engine_word_i is set on an accepted start, status_o is 3 whatever the codes are.
- R9: A start with bit 30 of engine_word_i clear is ignored. done_o stays 0 and every result output keeps its value.
- R10: For status 1, flip_mask_o has the single bit bit_off_o set and nflips_o is 1. For every other status, flip_mask_o, byte_off_o, bit_off_o and nflips_o are 0.
- R11: Without an accepted start, all result outputs hold their values from one cycle to the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Classify the presented chunk |
| stored_code_i | input | 24 | Code read from the spare area, byte 0 in [7:0] |
| engine_word_i | input | 32 | Engine result: inverted code in [23:0], failed in bit 28, valid in bit 30 |
| done_o | output | 1 | One-cycle pulse, result valid |
| status_o | output | 2 | 0 clean, 1 data error, 2 code-byte error, 3 uncorrectable |
| byte_off_o | output | 9 | Byte offset of the flipped data bit |
| bit_off_o | output | 3 | Bit offset of the flipped data bit |
| flip_mask_o | output | 8 | One-hot XOR mask for the faulty byte |
| nflips_o | output | 1 | Count of corrected bits (0 or 1) |

## Verification
The assertions assume that stored_code_i and engine_word_i are settled when start_i is high. They also assume that the valid and failed flags in engine_word_i are 0 or 1, never unknown. The stimulus changes every input only on the falling clock edge and drops start_i after each strobe, except in one deliberate back-to-back pair. Codes for each case are built from a chosen syndrome pair XORed onto the inverted engine word, so that every outcome class, including both extreme byte positions, is reached on purpose.

// File: rtl/ecc_syn_pkg.sv
package ecc_syn_pkg;
  typedef enum logic [1:0] {
    ST_CLEAN  = 2'd0,
    ST_DATA   = 2'd1,
    ST_CODE   = 2'd2,
    ST_UNCORR = 2'd3
  } ecc_status_e;
endpackage

// File: rtl/ecc_code_unpack.sv
module ecc_code_unpack #(
  parameter int HALF_W = 12,
  parameter bit INVERT = 1'b0
) (
  input  logic [2*HALF_W-1:0] code_i,
  output logic [HALF_W-1:0]   lo_o,
  output logic [HALF_W-1:0]   hi_o
);
  logic [2*HALF_W-1:0] code_n;

  generate
    if (INVERT) begin : g_inv
      assign code_n = ~code_i;
    end else begin : g_pass
      assign code_n = code_i;
    end
  endgenerate

  // byte0 + low nibble of byte1 | high nibble of byte1 + byte2
  assign lo_o = code_n[HALF_W-1:0];
  assign hi_o = code_n[2*HALF_W-1:HALF_W];
endmodule

// File: rtl/ecc_syndrome_classify.sv
module ecc_syndrome_classify
  import ecc_syn_pkg::*;
#(
  parameter int HALF_W     = 12,
  parameter int BIT_OFF_W  = 3,
  localparam int BYTE_OFF_W = HALF_W - BIT_OFF_W,
  localparam int MASK_W     = 1 << BIT_OFF_W
) (
  input  logic [HALF_W-1:0]     odd_i,
  input  logic [HALF_W-1:0]     even_i,
  input  logic                  failed_i,
  output ecc_status_e           status_o,
  output logic [BYTE_OFF_W-1:0] byte_off_o,
  output logic [BIT_OFF_W-1:0]  bit_off_o,
  output logic [MASK_W-1:0]     mask_o,
  output logic                  nflips_o
);
  logic [HALF_W-1:0] both;
  logic              is_clean, is_data, is_code;

  assign both     = odd_i | even_i;
  assign is_clean = (both == '0);
  assign is_data  = (odd_i == ~even_i);
  assign is_code  = ($countones(both) == 1);

  always_comb begin
    status_o   = ST_UNCORR;
    byte_off_o = '0;
    bit_off_o  = '0;
    mask_o     = '0;
    nflips_o   = 1'b0;
    if (failed_i) begin
      status_o = ST_UNCORR;
    end else if (is_clean) begin
      status_o = ST_CLEAN;
    end else if (is_data) begin
      status_o   = ST_DATA;
      byte_off_o = odd_i[HALF_W-1:BIT_OFF_W];
      bit_off_o  = odd_i[BIT_OFF_W-1:0];
      mask_o     = MASK_W'(1) << odd_i[BIT_OFF_W-1:0];
      nflips_o   = 1'b1;
    end else if (is_code) begin
      status_o = ST_CODE;
    end
  end
endmodule

// File: rtl/ecc_syndrome_corrector.sv
module ecc_syndrome_corrector
  import ecc_syn_pkg::*;
#(
  parameter int HALF_W    = 12,
  parameter int BIT_OFF_W = 3,
  parameter int WORD_W    = 32,
  parameter int VALID_BIT = 30,
  parameter int FAIL_BIT  = 28,
  localparam int CODE_W     = 2 * HALF_W,
  localparam int BYTE_OFF_W = HALF_W - BIT_OFF_W,
  localparam int MASK_W     = 1 << BIT_OFF_W
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  start_i,
  input  logic [CODE_W-1:0]     stored_code_i,
  input  logic [WORD_W-1:0]     engine_word_i,
  output logic                  done_o,
  output logic [1:0]            status_o,
  output logic [BYTE_OFF_W-1:0] byte_off_o,
  output logic [BIT_OFF_W-1:0]  bit_off_o,
  output logic [MASK_W-1:0]     flip_mask_o,
  output logic                  nflips_o
);
  logic [HALF_W-1:0] st_lo, st_hi, cp_lo, cp_hi;
  logic [HALF_W-1:0] syn_odd, syn_even;
  ecc_status_e       c_status;
  logic [BYTE_OFF_W-1:0] c_byte;
  logic [BIT_OFF_W-1:0]  c_bit;
  logic [MASK_W-1:0]     c_mask;
  logic                  c_nflips;
  logic                  accept;

  ecc_code_unpack #(.HALF_W(HALF_W), .INVERT(1'b0)) u_stored (
    .code_i(stored_code_i), .lo_o(st_lo), .hi_o(st_hi)
  );

  ecc_code_unpack #(.HALF_W(HALF_W), .INVERT(1'b1)) u_calc (
    .code_i(engine_word_i[CODE_W-1:0]), .lo_o(cp_lo), .hi_o(cp_hi)
  );

  assign syn_odd  = st_lo ^ cp_lo;
  assign syn_even = st_hi ^ cp_hi;

  ecc_syndrome_classify #(.HALF_W(HALF_W), .BIT_OFF_W(BIT_OFF_W)) u_cls (
    .odd_i(syn_odd), .even_i(syn_even), .failed_i(engine_word_i[FAIL_BIT]),
    .status_o(c_status), .byte_off_o(c_byte), .bit_off_o(c_bit),
    .mask_o(c_mask), .nflips_o(c_nflips)
  );

  assign accept = start_i && engine_word_i[VALID_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o      <= 1'b0;
      status_o    <= ST_CLEAN;
      byte_off_o  <= '0;
      bit_off_o   <= '0;
      flip_mask_o <= '0;
      nflips_o    <= 1'b0;
    end else begin
      done_o <= accept;
      if (accept) begin
        status_o    <= c_status;
        byte_off_o  <= c_byte;
        bit_off_o   <= c_bit;
        flip_mask_o <= c_mask;
        nflips_o    <= c_nflips;
      end
    end
  end

  a_r2_done_after_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> done_o);
  a_r9_no_done_if_invalid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(start_i && engine_word_i[VALID_BIT]) |=> !done_o);
  a_r11_hold_without_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(start_i && engine_word_i[VALID_BIT]) |=>
      ($stable(status_o) && $stable(byte_off_o) && $stable(flip_mask_o) && $stable(nflips_o)));
  a_r8_failed_uncorr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && engine_word_i[VALID_BIT] && engine_word_i[FAIL_BIT]) |=> status_o == 2'd3);
  a_r10_mask_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && status_o == 2'd1) |-> ($countones(flip_mask_o) == 1 && nflips_o));
  a_r10_mask_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o != 2'd1) |-> (flip_mask_o == '0 && !nflips_o && byte_off_o == '0));
endmodule

// File: tb/ecc_syndrome_corrector_tb.sv
module ecc_syndrome_corrector_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [23:0] stored = '0;
  logic [31:0] word = '0;
  logic        done;
  logic [1:0]  status;
  logic [8:0]  byte_off;
  logic [2:0]  bit_off;
  logic [7:0]  mask;
  logic        nflips;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  ecc_syndrome_corrector u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .stored_code_i(stored), .engine_word_i(word),
    .done_o(done), .status_o(status), .byte_off_o(byte_off),
    .bit_off_o(bit_off), .flip_mask_o(mask), .nflips_o(nflips)
  );

  // reference model state
  logic       e_done = 1'b0;
  int         e_status = 0, e_byte = 0, e_bit = 0, e_mask = 0, e_nf = 0;
  string      e_tag = "R1";

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      e_done <= 1'b0; e_status <= 0; e_byte <= 0; e_bit <= 0;
      e_mask <= 0; e_nf <= 0; e_tag <= "R1";
    end else if (start && word[30]) begin
      int b0, b1, b2, c0, c1, c2, lo_s, hi_s, lo_c, hi_c, odd, even;
      int st, by, bi, mk, nf;
      string tg;
      // R3: byte-wise unpacking, computed code is inverted engine bytes
      b0 = stored[7:0]; b1 = stored[15:8]; b2 = stored[23:16];
      c0 = ~word[7:0] & 255; c1 = ~word[15:8] & 255; c2 = ~word[23:16] & 255;
      lo_s = b0 + (b1 % 16) * 256;  hi_s = b1 / 16 + b2 * 16;
      lo_c = c0 + (c1 % 16) * 256;  hi_c = c1 / 16 + c2 * 16;
      odd = lo_s ^ lo_c; even = hi_s ^ hi_c;
      st = 3; by = 0; bi = 0; mk = 0; nf = 0; tg = "R7";
      if (word[28]) begin
        st = 3; tg = "R8";
      end else if (odd == 0 && even == 0) begin
        st = 0; tg = "R4";
      end else if (odd == (~even & 12'hFFF)) begin
        st = 1; by = odd / 8; bi = odd % 8; mk = 1 << bi; nf = 1; tg = "R3/R5";
      end else if ($countones(12'(odd | even)) == 1) begin
        st = 2; tg = "R6";
      end
      e_done <= 1'b1; e_status <= st; e_byte <= by; e_bit <= bi;
      e_mask <= mk; e_nf <= nf; e_tag <= tg;
    end else begin
      e_done <= 1'b0;
      e_tag <= (start ? "R9" : "R11");
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!finished) begin
      chk({"R2 done ", e_tag}, done, e_done);
      chk({"status ", e_tag}, status, e_status);
      chk({"byte_off ", e_tag}, byte_off, e_byte);
      chk({"bit_off ", e_tag}, bit_off, e_bit);
      chk({"R10 mask ", e_tag}, mask, e_mask);
      chk({"R10 nflips ", e_tag}, nflips, e_nf);
    end
  end

  // stored code = inverted engine code XOR syndrome pair {even, odd}
  task automatic run(input logic [31:0] w, input logic [11:0] odd, input logic [11:0] even);
    @(negedge clk);
    word   = w;
    stored = ~w[23:0] ^ {even, odd};
    start  = 1'b1;
    @(negedge clk);
    start  = 1'b0;
    @(negedge clk);
  endtask

  localparam logic [31:0] V = 32'h4000_0000;

  initial begin
    repeat (3) @(negedge clk);   // R1 checked during reset
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    run(V | 32'h00A5_3C71, 12'h000, 12'h000);  // R4 clean
    run(V | 32'h0012_3456, 12'h000, 12'hFFF);  // R5 byte 0 bit 0
    run(V | 32'h00FE_DCBA, 12'hFFF, 12'h000);  // R5 byte 511 bit 7
    run(V | 32'h0000_0000, 12'h965, ~12'h965); // R5 byte 300 bit 5
    run(V | 32'h0055_AA55, 12'h010, 12'h000);  // R6 odd half
    run(V | 32'h0033_CC33, 12'h000, 12'h800);  // R6 even half
    run(V | 32'h0011_2233, 12'h003, 12'h000);  // R7 two bits
    run(V | 32'h0044_5566, 12'h0F0, 12'hF00);  // R7 other
    run(V | 32'h1000_0000 | 32'h0012_3456, 12'h000, 12'hFFF); // R8 failed
    run(V | 32'h0000_1111, 12'h000, 12'hFFF);  // R5 then invalid
    run(32'h0000_2222, 12'h000, 12'h000);      // R9 invalid start ignored
    run(32'h1000_0000, 12'h003, 12'h000);      // R9 invalid with failed
    // back-to-back accepted starts, R2
    @(negedge clk);
    word = V | 32'h0077_8899; stored = ~word[23:0] ^ {12'hFFE, 12'h001}; start = 1'b1;
    @(negedge clk);
    word = V | 32'h0077_8899; stored = ~word[23:0]; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (4) @(negedge clk);                 // R11 hold
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #100000;
    if (!finished) begin
      finished = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule